// File: doc/BRIEF.md
# Latched Communication Fault Status Register

This block holds one byte of sticky fault flags for the communication, logic and memory side of a power management bus target. Single-cycle event pulses come in from the command decoder, the data validator, the packet error checker and a general communication monitor. Each pulse sets its own flag, and the flag stays set until something clears it. A memory fault arrives both as a pulse and as a level that persists while the fault persists. While that level is high, the memory flag is forced set again on every cycle.

Software reaches the byte through a simple register port at command code 0x7E. A read returns the flags combinationally and has no side effects. A write of ones clears the flags at those positions. There are two more clear paths. One is a global clear-faults strobe. The other is an output-enable strobe, raised when the output is turned on through its configured on/off mechanism. A live summary bit gives the OR of all flags and feeds the next level of status reporting.

Top module: `comm_fault_status`

## Requirements
- R1: After reset, all flags read as 0x00 at address 0x7E and summary_o is 0.
- R2: A read (bus_rd_i high) at address 0x7E returns the flag byte on bus_rdata_o in the same cycle. With no read, or with a read at any other address, bus_rdata_o is 0x00.
- R3: Bits 3, 2 and 0 always read as 0. Writing ones to them changes nothing.
- R4: An event pulse sets its flag at the next clock edge, and the flag stays set. The pulses map as follows: evt_bad_cmd_i to bit 7, evt_bad_data_i to bit 6, evt_pec_fail_i to bit 5, evt_mem_err_i to bit 4 and evt_other_i to bit 1.
- R5: A write (bus_wr_i high) at 0x7E clears each supported flag whose bus_wdata_i bit is 1. Flags whose written bit is 0 are left unchanged.
- R6: A clear_faults_i pulse clears all supported flags at the next edge.
- R7: An output_on_i pulse clears all supported flags at the next edge.
- R8: While mem_fault_lvl_i is high, bit 4 stays set and no clear path can drop it. Once the level is low, the flag remains set until a clear is applied.
- R9: summary_o equals the OR of all supported flags at all times.
- R10: When an event and any clear act on a flag in the same cycle, the flag ends up set.
- R11: Reads leave the flags unchanged, and so do writes at any address other than 0x7E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_bad_cmd_i | input | 1 | Pulse: invalid or unsupported command |
| evt_bad_data_i | input | 1 | Pulse: invalid or unsupported data |
| evt_pec_fail_i | input | 1 | Pulse: packet error check failed |
| evt_mem_err_i | input | 1 | Pulse: memory error detected |
| evt_other_i | input | 1 | Pulse: other communication error |
| mem_fault_lvl_i | input | 1 | Level: memory fault still present |
| clear_faults_i | input | 1 | Strobe: clear all flags |
| output_on_i | input | 1 | Strobe: output turned on, clear all flags |
| bus_addr_i | input | 8 | Register port command code |
| bus_wr_i | input | 1 | Register port write strobe |
| bus_rd_i | input | 1 | Register port read strobe |
| bus_wdata_i | input | 8 | Write data, ones clear flags |
| bus_rdata_o | output | 8 | Read data |
| summary_o | output | 1 | OR of all flags |

## Verification
The bench builds the block with its default parameters: an 8-bit command code and the register at 0x7E. With these values the bench can reach the neighbouring codes 0x7D and 0x7F. A write of all ones there shows that address decode is exact. Every flag position is driven one at a time and then in combinations. This covers selective write-one-to-clear and the ignored reserved bits. The memory level is held high across all three clear paths, and each clear path is also raced against a same-cycle event.

// File: rtl/comm_fault_pkg.sv
package comm_fault_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_CMD = 7;
  localparam int BIT_DAT = 6;
  localparam int BIT_PEC = 5;
  localparam int BIT_MEM = 4;
  localparam int BIT_OTH = 1;
  localparam logic [REG_W-1:0] SUPP_MASK = (REG_W'(1) << BIT_CMD) | (REG_W'(1) << BIT_DAT)
                                         | (REG_W'(1) << BIT_PEC) | (REG_W'(1) << BIT_MEM)
                                         | (REG_W'(1) << BIT_OTH);
endpackage

// File: rtl/fault_flag_cell.sv
module fault_flag_cell #(
  parameter bit SUPPORTED = 1'b1,
  parameter bit HAS_LVL   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, set_eff;

  assign set_eff = set_i | (HAS_LVL ? lvl_i : 1'b0);
  // set dominates clear so no event is lost
  assign flag_d  = SUPPORTED & (set_eff | (flag_q & ~clr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q & SUPPORTED;
endmodule

// File: rtl/fault_reg_port.sv
module fault_reg_port #(
  parameter int                ADDR_W = 8,
  parameter int                REG_W  = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h7E,
  parameter logic [REG_W-1:0]  MASK     = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  flags_i,
  output logic [REG_W-1:0]  w1c_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic hit;
  assign hit     = (addr_i == REG_ADDR);
  assign w1c_o   = (wr_i && hit) ? (wdata_i & MASK) : '0;
  assign rdata_o = (rd_i && hit) ? (flags_i & MASK) : '0;
endmodule

// File: rtl/fault_summary.sv
module fault_summary #(
  parameter int REG_W = 8
) (
  input  logic [REG_W-1:0] flags_i,
  output logic             any_o
);
  assign any_o = |flags_i;
endmodule

// File: rtl/comm_fault_status.sv
module comm_fault_status
  import comm_fault_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h7E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_bad_cmd_i,
  input  logic              evt_bad_data_i,
  input  logic              evt_pec_fail_i,
  input  logic              evt_mem_err_i,
  input  logic              evt_other_i,
  input  logic              mem_fault_lvl_i,
  input  logic              clear_faults_i,
  input  logic              output_on_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              summary_o
);
  logic [REG_W-1:0] evt_vec, lvl_vec, w1c_vec, clr_vec, flags;
  logic             clr_global;

  always_comb begin
    evt_vec          = '0;
    evt_vec[BIT_CMD] = evt_bad_cmd_i;
    evt_vec[BIT_DAT] = evt_bad_data_i;
    evt_vec[BIT_PEC] = evt_pec_fail_i;
    evt_vec[BIT_MEM] = evt_mem_err_i;
    evt_vec[BIT_OTH] = evt_other_i;
    lvl_vec          = '0;
    lvl_vec[BIT_MEM] = mem_fault_lvl_i;
  end

  assign clr_global = clear_faults_i | output_on_i;
  assign clr_vec    = w1c_vec | {REG_W{clr_global}};

  fault_reg_port #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .REG_ADDR(REG_ADDR), .MASK(SUPP_MASK)
  ) u_port (
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .rd_i   (bus_rd_i),
    .wdata_i(bus_wdata_i),
    .flags_i(flags),
    .w1c_o  (w1c_vec),
    .rdata_o(bus_rdata_o)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_flag
    fault_flag_cell #(
      .SUPPORTED(SUPP_MASK[i]),
      .HAS_LVL  (i == BIT_MEM)
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt_vec[i]),
      .lvl_i (lvl_vec[i]),
      .clr_i (clr_vec[i]),
      .flag_o(flags[i])
    );
  end

  fault_summary #(.REG_W(REG_W)) u_sum (
    .flags_i(flags),
    .any_o  (summary_o)
  );
endmodule

// File: rtl/comm_fault_status_checker.sv
module comm_fault_status_checker #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h7E
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_bad_cmd_i,
  input logic              evt_pec_fail_i,
  input logic              evt_mem_err_i,
  input logic              mem_fault_lvl_i,
  input logic              clear_faults_i,
  input logic              output_on_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic              summary_o,
  input logic [7:0]        flags_i,
  input logic [7:0]        evt_all_i
);
  a_r3_unsup_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[3] == 1'b0) && (flags_i[2] == 1'b0) && (flags_i[0] == 1'b0));

  a_r2_read_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == REG_ADDR) |-> (bus_rdata_o == flags_i));

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_i || bus_addr_i != REG_ADDR) |-> (bus_rdata_o == 8'h00));

  a_r10_cmd_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_bad_cmd_i |=> flags_i[7]);

  a_r10_pec_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_pec_fail_i |=> flags_i[5]);

  a_r8_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_fault_lvl_i || evt_mem_err_i) |=> flags_i[4]);

  a_r6_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_faults_i && evt_all_i == 8'h00 && !mem_fault_lvl_i) |=> (flags_i == 8'h00));

  a_r7_output_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (output_on_i && evt_all_i == 8'h00 && !mem_fault_lvl_i) |=> (flags_i == 8'h00));

  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == REG_ADDR && evt_all_i == 8'h00 && !mem_fault_lvl_i)
      |=> ((flags_i & ~$past(bus_wdata_i)) == ($past(flags_i) & ~$past(bus_wdata_i))
           && ((flags_i & $past(bus_wdata_i)) == 8'h00)));

  a_r11_no_side_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_all_i == 8'h00 && !mem_fault_lvl_i && !clear_faults_i && !output_on_i
     && !(bus_wr_i && bus_addr_i == REG_ADDR)) |=> $stable(flags_i));

  a_r9_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    summary_o == (flags_i != 8'h00));
endmodule

bind comm_fault_status comm_fault_status_checker #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .evt_bad_cmd_i  (evt_bad_cmd_i),
  .evt_pec_fail_i (evt_pec_fail_i),
  .evt_mem_err_i  (evt_mem_err_i),
  .mem_fault_lvl_i(mem_fault_lvl_i),
  .clear_faults_i (clear_faults_i),
  .output_on_i    (output_on_i),
  .bus_addr_i     (bus_addr_i),
  .bus_wr_i       (bus_wr_i),
  .bus_rd_i       (bus_rd_i),
  .bus_wdata_i    (bus_wdata_i),
  .bus_rdata_o    (bus_rdata_o),
  .summary_o      (summary_o),
  .flags_i        (flags),
  .evt_all_i      (evt_vec)
);

// File: tb/comm_fault_status_bench.sv
`timescale 1ns/1ps
module comm_fault_status_bench;
  localparam logic [7:0] A_REG = 8'h7E;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       e_cmd = 0, e_dat = 0, e_pec = 0, e_mem = 0, e_oth = 0;
  logic       mem_lvl = 0, clr_all = 0, out_on = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       wr = 0, rd = 0;
  logic [7:0] rdata;
  logic       summ;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  comm_fault_status u_comm_fault_status (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_bad_cmd_i(e_cmd), .evt_bad_data_i(e_dat), .evt_pec_fail_i(e_pec),
    .evt_mem_err_i(e_mem), .evt_other_i(e_oth), .mem_fault_lvl_i(mem_lvl),
    .clear_faults_i(clr_all), .output_on_i(out_on),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .summary_o(summ)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic read_reg(logic [7:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    tick();
    rd = 1'b0; addr = 8'h00;
  endtask

  task automatic write_reg(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic pulse_evts(logic [7:0] m);
    e_cmd = m[7]; e_dat = m[6]; e_pec = m[5]; e_mem = m[4]; e_oth = m[1];
    tick();
    e_cmd = 0; e_dat = 0; e_pec = 0; e_mem = 0; e_oth = 0;
  endtask

  task automatic expect_reg(string req, logic [7:0] exp);
    logic [7:0] v;
    read_reg(A_REG, v);
    check(req, v, exp);
    check({req, " summary R9"}, {7'd0, summ}, {7'd0, exp != 8'h00});
  endtask

  task automatic t_reset();
    expect_reg("R1 reset", 8'h00);
  endtask

  task automatic t_each_event();
    logic [7:0] bits [5] = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h02};
    for (int i = 0; i < 5; i++) begin
      pulse_evts(bits[i]);
      tick();
      expect_reg("R4 single event latch", bits[i]);
      clr_all = 1'b1; tick(); clr_all = 1'b0;
    end
    pulse_evts(8'hF2);
    expect_reg("R4 all events", 8'hF2);
  endtask

  task automatic t_read_idle();
    logic [7:0] v;
    read_reg(8'h7D, v);
    check("R2 read other addr", v, 8'h00);
    #1 check("R2 no read strobe", rdata, 8'h00);
    expect_reg("R11 reads no side effect", 8'hF2);
    expect_reg("R11 second read", 8'hF2);
  endtask

  task automatic t_other_addr();
    write_reg(8'h7D, 8'hFF);
    write_reg(8'h7F, 8'hFF);
    expect_reg("R11 write other addr", 8'hF2);
  endtask

  task automatic t_w1c();
    write_reg(A_REG, 8'h0D);
    expect_reg("R3 write reserved bits", 8'hF2);
    write_reg(A_REG, 8'h00);
    expect_reg("R5 write zero", 8'hF2);
    write_reg(A_REG, 8'hA0);
    expect_reg("R5 selective clear", 8'h52);
    write_reg(A_REG, 8'h52);
    expect_reg("R5 clear rest", 8'h00);
  endtask

  task automatic t_clear_paths();
    pulse_evts(8'hF2);
    clr_all = 1'b1; tick(); clr_all = 1'b0;
    expect_reg("R6 clear faults", 8'h00);
    pulse_evts(8'hC2);
    out_on = 1'b1; tick(); out_on = 1'b0;
    expect_reg("R7 output on", 8'h00);
  endtask

  task automatic t_mem_level();
    mem_lvl = 1'b1;
    tick();
    expect_reg("R8 level sets", 8'h10);
    clr_all = 1'b1; tick(); clr_all = 1'b0;
    expect_reg("R8 clear faults blocked", 8'h10);
    out_on = 1'b1; tick(); out_on = 1'b0;
    expect_reg("R8 output on blocked", 8'h10);
    write_reg(A_REG, 8'h10);
    expect_reg("R8 w1c blocked", 8'h10);
    mem_lvl = 1'b0;
    tick(); tick();
    expect_reg("R8 still latched after level drop", 8'h10);
    write_reg(A_REG, 8'h10);
    expect_reg("R8 cleared after drop", 8'h00);
  endtask

  task automatic t_set_wins();
    pulse_evts(8'h80);
    e_pec = 1'b1; clr_all = 1'b1;
    tick();
    e_pec = 1'b0; clr_all = 1'b0;
    expect_reg("R10 event vs clear faults", 8'h20);
    e_pec = 1'b1; addr = A_REG; wdata = 8'h20; wr = 1'b1;
    tick();
    e_pec = 1'b0; wr = 1'b0;
    expect_reg("R10 event vs w1c", 8'h20);
    e_oth = 1'b1; out_on = 1'b1;
    tick();
    e_oth = 1'b0; out_on = 1'b0;
    expect_reg("R10 event vs output on", 8'h02);
    clr_all = 1'b1; tick(); clr_all = 1'b0;
    expect_reg("R6 final clear", 8'h00);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_each_event();
    t_read_idle();
    t_other_addr();
    t_w1c();
    t_clear_paths();
    t_mem_level();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule